// File: doc/BRIEF.md
# Wave Dispatch Scheduler

This block places waves onto an array of compute units. Every compute unit holds a fixed number of SIMDs, and every SIMD can keep a bounded number of resident waves. A counter per SIMD tracks how many waves it holds. A grant adds one to that counter, and a wave-complete report subtracts one. An upstream launcher offers one request at a time. A request is a single fragment wave, a single vertex wave or a compute workgroup of several waves. Each granted wave appears on the grant port as a compute-unit index and a SIMD index.

Each request kind has its own placement policy. Fragment waves gather on one compute unit, one per SIMD, until that unit has received one wave per SIMD; the fragment pointer then moves on. Vertex waves and workgroups rotate through the compute units, one per unit. A workgroup is held together: all of its waves go to one compute unit, and that unit must have enough free slots for the whole group.

The request port follows valid/ready rules. `req_ready` depends on the kind and size being offered and on current occupancy. A request that cannot be placed waits with `req_valid` high, and its fields must stay stable until it is taken. It is taken once a completion frees enough room. The grant port has no back-pressure. Each wave produces one `grant_valid` pulse, and the receiver must accept it.

Top module: `wave_dispatch`

## Requirements
- R1: After reset every SIMD is empty, `grant_valid` is low, and `req_ready` is high for a single fragment or vertex request. Every granted index is below the compute-unit count and the SIMD count.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its first wave grant is registered on that same edge, so it is visible in the following cycle. Grants come only from taken requests, and each wave is granted exactly once.
- R3: Kind code 2'b00 is a fragment wave. Successive fragment waves go to SIMD 0, 1, 2, … of the current fragment compute unit, one per SIMD. After SIMDS waves have landed on that unit, the fragment pointer moves to the next compute unit, wrapping modulo NUM_CU, and the next group starts again at SIMD 0.
- R4: When the fragment SIMD in turn is full, the wave goes to the next SIMD of the same compute unit, in rising order with wrap, that has a free slot.
- R5: When the current fragment compute unit has no free slot at all, the wave goes to the next compute unit, in rising order with wrap, that has one. That unit becomes the current fragment unit, and the wave counts as the first of its group.
- R6: Kind code 2'b01 is a vertex wave. It goes to the first compute unit, searching upward from the vertex pointer with wrap, that has any free slot. Within that unit it takes the least occupied SIMD, with the lowest index winning a tie. The vertex pointer then moves to the unit after the chosen one.
- R7: Kind codes 2'b10 and 2'b11 are a compute workgroup of `req_waves` waves; a size of 0 is handled as 1. The waves are granted on one compute unit in consecutive cycles, each to the least occupied SIMD (lowest index on a tie). `req_ready` stays low until the last wave, which is the one grant that carries `grant_last`. Fragment and vertex grants always carry `grant_last`.
- R8: A workgroup goes to the first compute unit, searching upward from the workgroup pointer with wrap, whose free slots summed over its SIMDs are at least the group size. Units with too little room are skipped, and the workgroup pointer then moves past the chosen unit.
- R9: While no compute unit can take the offered request, `req_ready` stays low and nothing is granted. Once a completion frees enough room, the request is taken.
- R10: A SIMD never holds more than MAX_WAVES waves. A completion (`done_valid` with a CU and SIMD index) frees one slot. A completion aimed at an empty SIMD is ignored and leaves that SIMD at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A launch request is offered |
| req_ready | output | 1 | The offered request is taken on this edge |
| req_kind | input | 2 | 00 fragment, 01 vertex, 1x compute workgroup |
| req_waves | input | WAVE_W | Workgroup wave count (0 handled as 1) |
| grant_valid | output | 1 | One wave is granted this cycle |
| grant_cu | output | CU_W | Compute unit of the granted wave |
| grant_simd | output | SIMD_W | SIMD of the granted wave |
| grant_last | output | 1 | Final wave of the request |
| done_valid | input | 1 | A resident wave has completed |
| done_cu | input | CU_W | Compute unit of the completed wave |
| done_simd | input | SIMD_W | SIMD of the completed wave |

## Verification
The bench builds the block with three compute units, four SIMDs and three waves per SIMD. With three units, the pointer wrap is checked on a count that is not a power of two. With only three waves per SIMD, full SIMDs, full compute units and a completely full array are reached within a few dozen grants. That brings the fragment SIMD skip, the fragment unit skip, workgroup units passed over for lack of room, and the stall-until-completion path within reach. Draining the array and then sending one extra completion to an empty SIMD exposes any counter underflow: a workgroup that exactly fills one unit must then still land evenly.

// File: rtl/wd_pkg.sv
package wd_pkg;

  typedef enum logic [1:0] {
    KIND_FRAG   = 2'b00,
    KIND_VERT   = 2'b01,
    KIND_WG     = 2'b10,
    KIND_WG_ALT = 2'b11
  } wave_kind_e;

endpackage

// File: rtl/wd_rr_pick.sv
module wd_rr_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  elig,
  input  logic [IW-1:0] start,
  output logic          found,
  output logic [IW-1:0] idx
);

  // first eligible entry at or after start, wrapping
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      int p;
      p = int'(start) + i;
      if (p >= N) p = p - N;
      if (!found && elig[p]) begin
        found = 1'b1;
        idx   = IW'(p);
      end
    end
  end

endmodule

// File: rtl/wd_simd_pick.sv
module wd_simd_pick #(
  parameter int SIMDS     = 4,
  parameter int MAX_WAVES = 10,
  parameter bit LEAST     = 1'b0,
  localparam int OCC_W  = $clog2(MAX_WAVES + 1),
  localparam int SIMD_W = (SIMDS > 1) ? $clog2(SIMDS) : 1
) (
  input  logic [SIMDS*OCC_W-1:0] occ,
  input  logic [SIMD_W-1:0]      start,
  output logic                   found,
  output logic [SIMD_W-1:0]      idx
);

  generate
    if (LEAST) begin : g_least
      // lowest occupancy among non-full SIMDs; ties go to the first seen from start
      logic [OCC_W-1:0] best;
      always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < SIMDS; i++) begin
          int p;
          logic [OCC_W-1:0] o;
          p = int'(start) + i;
          if (p >= SIMDS) p = p - SIMDS;
          o = occ[p*OCC_W +: OCC_W];
          if (o < OCC_W'(MAX_WAVES) && (!found || o < best)) begin
            found = 1'b1;
            idx   = SIMD_W'(p);
            best  = o;
          end
        end
      end
    end else begin : g_rotate
      logic [SIMDS-1:0] has_room;
      for (genvar s = 0; s < SIMDS; s++) begin : g_room
        assign has_room[s] = occ[s*OCC_W +: OCC_W] < OCC_W'(MAX_WAVES);
      end
      wd_rr_pick #(.N(SIMDS)) u_rr (
        .elig  (has_room),
        .start (start),
        .found (found),
        .idx   (idx)
      );
    end
  endgenerate

endmodule

// File: rtl/wd_occupancy.sv
module wd_occupancy #(
  parameter int NUM_CU    = 4,
  parameter int SIMDS     = 4,
  parameter int MAX_WAVES = 10,
  localparam int CU_W   = (NUM_CU > 1) ? $clog2(NUM_CU) : 1,
  localparam int SIMD_W = (SIMDS > 1) ? $clog2(SIMDS) : 1,
  localparam int OCC_W  = $clog2(MAX_WAVES + 1),
  localparam int SUM_W  = $clog2(SIMDS * MAX_WAVES + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          inc_valid,
  input  logic [CU_W-1:0]               inc_cu,
  input  logic [SIMD_W-1:0]             inc_simd,
  input  logic                          dec_valid,
  input  logic [CU_W-1:0]               dec_cu,
  input  logic [SIMD_W-1:0]             dec_simd,
  output logic [NUM_CU*SIMDS*OCC_W-1:0] occ_flat,
  output logic [NUM_CU*SIMDS-1:0]       simd_free,
  output logic [NUM_CU*SUM_W-1:0]       cu_free_sum
);

  generate
    for (genvar c = 0; c < NUM_CU; c++) begin : g_cu
      for (genvar s = 0; s < SIMDS; s++) begin : g_simd
        logic [OCC_W-1:0] cnt;
        logic             up;
        logic             down;

        assign up   = inc_valid && (inc_cu == CU_W'(c)) && (inc_simd == SIMD_W'(s));
        assign down = dec_valid && (dec_cu == CU_W'(c)) && (dec_simd == SIMD_W'(s))
                      && (cnt != '0);

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)            cnt <= '0;
          else if (up && !down)  cnt <= cnt + 1'b1;
          else if (down && !up)  cnt <= cnt - 1'b1;
        end

        assign occ_flat[(c*SIMDS+s)*OCC_W +: OCC_W] = cnt;
        assign simd_free[c*SIMDS+s]                 = cnt < OCC_W'(MAX_WAVES);
      end

      logic [SUM_W-1:0] room;
      always_comb begin
        room = '0;
        for (int s = 0; s < SIMDS; s++) begin
          room = room + (SUM_W'(MAX_WAVES) - SUM_W'(occ_flat[(c*SIMDS+s)*OCC_W +: OCC_W]));
        end
      end
      assign cu_free_sum[c*SUM_W +: SUM_W] = room;
    end
  endgenerate

endmodule

// File: rtl/wave_dispatch.sv
module wave_dispatch #(
  parameter int NUM_CU    = 4,
  parameter int SIMDS     = 4,
  parameter int MAX_WAVES = 10,
  localparam int CU_W   = (NUM_CU > 1) ? $clog2(NUM_CU) : 1,
  localparam int SIMD_W = (SIMDS > 1) ? $clog2(SIMDS) : 1,
  localparam int WAVE_W = $clog2(SIMDS * MAX_WAVES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [WAVE_W-1:0] req_waves,
  output logic              grant_valid,
  output logic [CU_W-1:0]   grant_cu,
  output logic [SIMD_W-1:0] grant_simd,
  output logic              grant_last,
  input  logic              done_valid,
  input  logic [CU_W-1:0]   done_cu,
  input  logic [SIMD_W-1:0] done_simd
);
  import wd_pkg::*;

  localparam int OCC_W = $clog2(MAX_WAVES + 1);
  localparam int CNT_W = $clog2(SIMDS + 1);
  localparam int ROW_W = SIMDS * OCC_W;

  function automatic logic [CU_W-1:0] cu_after(input logic [CU_W-1:0] x);
    return (int'(x) == NUM_CU - 1) ? '0 : x + 1'b1;
  endfunction

  function automatic logic [SIMD_W-1:0] simd_after(input logic [SIMD_W-1:0] x);
    return (int'(x) == SIMDS - 1) ? '0 : x + 1'b1;
  endfunction

  // ---------------- request decode ----------------
  wave_kind_e  kind;
  logic        is_frag, is_vert, is_wg;
  logic [WAVE_W-1:0] eff_waves;

  assign kind      = wave_kind_e'(req_kind);
  assign is_frag   = (kind == KIND_FRAG);
  assign is_vert   = (kind == KIND_VERT);
  assign is_wg     = (kind == KIND_WG) || (kind == KIND_WG_ALT);
  assign eff_waves = (req_waves == '0) ? WAVE_W'(1) : req_waves;

  // ---------------- state ----------------
  logic              busy;
  logic [CU_W-1:0]   wg_cu;
  logic [WAVE_W-1:0] wg_left;
  logic [CU_W-1:0]   frag_cu;
  logic [CNT_W-1:0]  frag_cnt;
  logic [SIMD_W-1:0] frag_next;
  logic [CU_W-1:0]   vert_ptr;
  logic [CU_W-1:0]   wg_ptr;

  // ---------------- occupancy ----------------
  logic                          emit;
  logic [CU_W-1:0]               emit_cu;
  logic [SIMD_W-1:0]             emit_simd;
  logic [NUM_CU*ROW_W-1:0]       occ_flat;
  logic [NUM_CU*SIMDS-1:0]       simd_free;
  logic [NUM_CU*WAVE_W-1:0]      cu_free_sum;

  wd_occupancy #(.NUM_CU(NUM_CU), .SIMDS(SIMDS), .MAX_WAVES(MAX_WAVES)) u_occ (
    .clk         (clk),
    .rst_n       (rst_n),
    .inc_valid   (emit),
    .inc_cu      (emit_cu),
    .inc_simd    (emit_simd),
    .dec_valid   (done_valid),
    .dec_cu      (done_cu),
    .dec_simd    (done_simd),
    .occ_flat    (occ_flat),
    .simd_free   (simd_free),
    .cu_free_sum (cu_free_sum)
  );

  // ---------------- per-CU eligibility ----------------
  logic [NUM_CU-1:0] cu_any_room;
  logic [NUM_CU-1:0] cu_wg_fits;

  generate
    for (genvar c = 0; c < NUM_CU; c++) begin : g_elig
      assign cu_any_room[c] = |simd_free[c*SIMDS +: SIMDS];
      assign cu_wg_fits[c]  = cu_free_sum[c*WAVE_W +: WAVE_W] >= eff_waves;
    end
  endgenerate

  // ---------------- CU choice per kind ----------------
  logic            frag_hit, vert_hit, wg_hit;
  logic [CU_W-1:0] frag_sel, vert_sel, wg_sel;

  wd_rr_pick #(.N(NUM_CU)) u_frag_cu (
    .elig (cu_any_room), .start (frag_cu), .found (frag_hit), .idx (frag_sel)
  );
  wd_rr_pick #(.N(NUM_CU)) u_vert_cu (
    .elig (cu_any_room), .start (vert_ptr), .found (vert_hit), .idx (vert_sel)
  );
  wd_rr_pick #(.N(NUM_CU)) u_wg_cu (
    .elig (cu_wg_fits), .start (wg_ptr), .found (wg_hit), .idx (wg_sel)
  );

  // ---------------- SIMD choice ----------------
  logic [CU_W-1:0]   bal_cu;
  logic [ROW_W-1:0]  frag_row, bal_row;
  logic [SIMD_W-1:0] frag_start;
  logic              frag_simd_ok, bal_ok;
  logic [SIMD_W-1:0] frag_simd, bal_simd;

  assign bal_cu     = busy ? wg_cu : (is_wg ? wg_sel : vert_sel);
  assign frag_start = (frag_sel == frag_cu) ? frag_next : '0;

  always_comb begin
    frag_row = '0;
    bal_row  = '0;
    for (int c = 0; c < NUM_CU; c++) begin
      if (frag_sel == CU_W'(c)) frag_row = occ_flat[c*ROW_W +: ROW_W];
      if (bal_cu == CU_W'(c))   bal_row  = occ_flat[c*ROW_W +: ROW_W];
    end
  end

  wd_simd_pick #(.SIMDS(SIMDS), .MAX_WAVES(MAX_WAVES), .LEAST(1'b0)) u_frag_simd (
    .occ (frag_row), .start (frag_start), .found (frag_simd_ok), .idx (frag_simd)
  );
  wd_simd_pick #(.SIMDS(SIMDS), .MAX_WAVES(MAX_WAVES), .LEAST(1'b1)) u_bal_simd (
    .occ (bal_row), .start ('0), .found (bal_ok), .idx (bal_simd)
  );

  // ---------------- handshake ----------------
  logic can_take;
  logic accept;
  logic last_now;

  always_comb begin
    if (is_frag)      can_take = frag_hit && frag_simd_ok;
    else if (is_vert) can_take = vert_hit && bal_ok;
    else              can_take = wg_hit && bal_ok;
  end

  assign req_ready = !busy && can_take;
  assign accept    = req_valid && req_ready;
  assign emit      = accept || busy;
  assign emit_cu   = busy ? wg_cu : (is_frag ? frag_sel : bal_cu);
  assign emit_simd = (!busy && is_frag) ? frag_simd : bal_simd;
  assign last_now  = busy ? (wg_left == WAVE_W'(1)) : !(is_wg && eff_waves > WAVE_W'(1));

  // ---------------- grant register ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_valid <= 1'b0;
      grant_cu    <= '0;
      grant_simd  <= '0;
      grant_last  <= 1'b0;
    end else begin
      grant_valid <= emit;
      grant_cu    <= emit_cu;
      grant_simd  <= emit_simd;
      grant_last  <= emit && last_now;
    end
  end

  // ---------------- workgroup sequencing ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      wg_cu   <= '0;
      wg_left <= '0;
      wg_ptr  <= '0;
    end else if (busy) begin
      wg_left <= wg_left - 1'b1;
      if (wg_left == WAVE_W'(1)) busy <= 1'b0;
    end else if (accept && is_wg) begin
      wg_cu   <= wg_sel;
      wg_left <= eff_waves - 1'b1;
      busy    <= eff_waves > WAVE_W'(1);
      wg_ptr  <= cu_after(wg_sel);
    end
  end

  // ---------------- vertex rotation ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  vert_ptr <= '0;
    else if (accept && is_vert)  vert_ptr <= cu_after(vert_sel);
  end

  // ---------------- fragment grouping ----------------
  logic [CNT_W-1:0] frag_cnt_n;
  assign frag_cnt_n = (frag_sel == frag_cu) ? frag_cnt + 1'b1 : CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frag_cu   <= '0;
      frag_cnt  <= '0;
      frag_next <= '0;
    end else if (accept && is_frag) begin
      if (frag_cnt_n == CNT_W'(SIMDS)) begin
        frag_cu   <= cu_after(frag_sel);
        frag_cnt  <= '0;
        frag_next <= '0;
      end else begin
        frag_cu   <= frag_sel;
        frag_cnt  <= frag_cnt_n;
        frag_next <= simd_after(frag_simd);
      end
    end
  end

endmodule

// File: rtl/wd_checker.sv
module wd_checker #(
  parameter int NUM_CU    = 4,
  parameter int SIMDS     = 4,
  parameter int MAX_WAVES = 10,
  localparam int CU_W   = (NUM_CU > 1) ? $clog2(NUM_CU) : 1,
  localparam int SIMD_W = (SIMDS > 1) ? $clog2(SIMDS) : 1,
  localparam int WAVE_W = $clog2(SIMDS * MAX_WAVES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_kind,
  input logic [WAVE_W-1:0] req_waves,
  input logic              grant_valid,
  input logic [CU_W-1:0]   grant_cu,
  input logic [SIMD_W-1:0] grant_simd,
  input logic              grant_last
);

  // R1
  index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> ({1'b0, grant_cu} < (CU_W+1)'(NUM_CU)) &&
                    ({1'b0, grant_simd} < (SIMD_W+1)'(SIMDS)));

  // R2
  accept_to_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> grant_valid);

  // R2
  grant_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> ($past(req_valid && req_ready) || $past(grant_valid && !grant_last)));

  // R7
  wg_same_cu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !grant_last) |=> (grant_valid && grant_cu == $past(grant_cu)));

  // R7
  wg_ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind[1] && req_waves > WAVE_W'(1)) |=> !req_ready);

  // R7
  single_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_kind[1]) |=> grant_last);

endmodule

bind wave_dispatch wd_checker #(.NUM_CU(NUM_CU), .SIMDS(SIMDS), .MAX_WAVES(MAX_WAVES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_kind    (req_kind),
  .req_waves   (req_waves),
  .grant_valid (grant_valid),
  .grant_cu    (grant_cu),
  .grant_simd  (grant_simd),
  .grant_last  (grant_last)
);

// File: tb/tb_wave_dispatch.sv
module tb_wave_dispatch;
  import wd_pkg::*;

  localparam int NC = 3;
  localparam int NS = 4;
  localparam int MW = 3;
  localparam int CU_W   = 2;
  localparam int SIMD_W = 2;
  localparam int WAVE_W = $clog2(NS * MW + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [1:0]        req_kind = 2'b00;
  logic [WAVE_W-1:0] req_waves = '0;
  logic              grant_valid;
  logic [CU_W-1:0]   grant_cu;
  logic [SIMD_W-1:0] grant_simd;
  logic              grant_last;
  logic              done_valid = 1'b0;
  logic [CU_W-1:0]   done_cu = '0;
  logic [SIMD_W-1:0] done_simd = '0;

  always #4 clk = ~clk;

  wave_dispatch #(.NUM_CU(NC), .SIMDS(NS), .MAX_WAVES(MW)) dut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready),
    .req_kind (req_kind), .req_waves (req_waves),
    .grant_valid (grant_valid), .grant_cu (grant_cu),
    .grant_simd (grant_simd), .grant_last (grant_last),
    .done_valid (done_valid), .done_cu (done_cu), .done_simd (done_simd)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic check_eq(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // ---------------- reference model ----------------
  typedef struct {
    int    cu;
    int    simd;
    bit    last;
    string tag;
  } exp_t;

  exp_t q[$];
  int occ[NC][NS];
  int f_cu, f_cnt, f_next, v_ptr, w_ptr;

  function automatic bit any_room(int c);
    for (int s = 0; s < NS; s++) if (occ[c][s] < MW) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int room_sum(int c);
    int r = 0;
    for (int s = 0; s < NS; s++) r += MW - occ[c][s];
    return r;
  endfunction

  function automatic int least_simd(int c);
    int b = -1;
    for (int s = 0; s < NS; s++)
      if (occ[c][s] < MW && (b < 0 || occ[c][s] < occ[c][b])) b = s;
    return b;
  endfunction

  function automatic int find_cu(int start, bit wg, int need);
    for (int i = 0; i < NC; i++) begin
      int c = (start + i) % NC;
      if (wg ? (room_sum(c) >= need) : any_room(c)) return c;
    end
    return -1;
  endfunction

  function automatic bit fits(logic [1:0] k, int n);
    int need = (n == 0) ? 1 : n;
    if (k == 2'b00) return find_cu(f_cu, 1'b0, 0) >= 0;
    if (k == 2'b01) return find_cu(v_ptr, 1'b0, 0) >= 0;
    return find_cu(w_ptr, 1'b1, need) >= 0;
  endfunction

  function automatic void push(int c, int s, bit l, string t);
    exp_t e;
    e.cu = c; e.simd = s; e.last = l; e.tag = t;
    q.push_back(e);
    occ[c][s]++;
  endfunction

  // called only when fits() holds
  function automatic void predict(logic [1:0] k, int n);
    int need = (n == 0) ? 1 : n;
    if (k == 2'b00) begin
      int c = find_cu(f_cu, 1'b0, 0);
      int st = (c == f_cu) ? f_next : 0;
      int s = -1;
      string t = "R3";
      int cnt;
      for (int j = 0; j < NS && s < 0; j++)
        if (occ[c][(st + j) % NS] < MW) s = (st + j) % NS;
      if (s != st) t = "R4";
      if (c != f_cu) t = "R5";
      push(c, s, 1'b1, t);
      cnt = (c == f_cu) ? f_cnt + 1 : 1;
      if (cnt == NS) begin
        f_cu = (c + 1) % NC; f_cnt = 0; f_next = 0;
      end else begin
        f_cu = c; f_cnt = cnt; f_next = (s + 1) % NS;
      end
    end else if (k == 2'b01) begin
      int c = find_cu(v_ptr, 1'b0, 0);
      push(c, least_simd(c), 1'b1, "R6");
      v_ptr = (c + 1) % NC;
    end else begin
      int c = find_cu(w_ptr, 1'b1, need);
      string t = (c != w_ptr) ? "R8" : "R7";
      for (int w = 0; w < need; w++) push(c, least_simd(c), w == need - 1, t);
      w_ptr = (c + 1) % NC;
    end
  endfunction

  // ---------------- driver ----------------
  task automatic send(logic [1:0] k, int n);
    bit ok = fits(k, n);
    int need = (n == 0) ? 1 : n;
    @(negedge clk);
    req_valid = 1'b1;
    req_kind  = k;
    req_waves = WAVE_W'(n);
    #1;
    check_eq(ok ? "R2" : "R9", "req_ready", int'(req_ready), int'(ok));
    if (!ok || !req_ready) begin
      req_valid = 1'b0;
      return;
    end
    predict(k, n);
    @(negedge clk);
    req_valid = 1'b0;
    if (k[1]) repeat (need - 1) @(negedge clk);
  endtask

  task automatic complete(int c, int s);
    @(negedge clk);
    done_valid = 1'b1;
    done_cu    = CU_W'(c);
    done_simd  = SIMD_W'(s);
    @(negedge clk);
    done_valid = 1'b0;
    if (occ[c][s] > 0) occ[c][s]--;
  endtask

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && grant_valid) begin
      if (q.size() == 0) begin
        check_eq("R2", "unexpected grant", 1, 0);
      end else begin
        e = q.pop_front();
        check_eq(e.tag, "grant_cu", int'(grant_cu), e.cu);
        check_eq(e.tag, "grant_simd", int'(grant_simd), e.simd);
        check_eq("R7", "grant_last", int'(grant_last), int'(e.last));
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    check_eq("R2", "watchdog expired", 1, 0);
    summary();
  end

  // ---------------- stimulus ----------------
  initial begin
    for (int c = 0; c < NC; c++) for (int s = 0; s < NS; s++) occ[c][s] = 0;
    f_cu = 0; f_cnt = 0; f_next = 0; v_ptr = 0; w_ptr = 0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check_eq("R1", "grant_valid in reset", int'(grant_valid), 0);
    rst_n = 1'b1;
    #1;
    check_eq("R1", "req_ready after reset", int'(req_ready), 1);

    // R3: fragment grouping across a CU boundary
    repeat (5) send(2'b00, 0);
    // R6: vertex rotation
    repeat (4) send(2'b01, 0);
    // R7: workgroups of several sizes, including size 0 and the alias code
    send(2'b10, 6);
    send(2'b11, 0);
    send(2'b10, 5);
    // R8: a workgroup larger than the room on the pointer's CU
    send(2'b10, 9);

    // R4 R5 R10: fill every slot with fragments
    for (int i = 0; i < NC * NS * MW; i++) if (fits(2'b00, 0)) send(2'b00, 0);
    check_eq("R10", "model full", int'(fits(2'b01, 0)), 0);

    // R9: stall until a completion frees CU 1 SIMD 2
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'b00; req_waves = '0;
    for (int i = 0; i < 4; i++) begin
      #1;
      check_eq("R9", "req_ready while full", int'(req_ready), 0);
      @(negedge clk);
    end
    done_valid = 1'b1; done_cu = CU_W'(1); done_simd = SIMD_W'(2);
    @(negedge clk);
    done_valid = 1'b0;
    occ[1][2]--;
    #1;
    check_eq("R9", "req_ready after completion", int'(req_ready), 1);
    predict(2'b00, 0);
    @(negedge clk);
    req_valid = 1'b0;

    // R10: drain, then complete an empty SIMD; a unit-filling workgroup must still spread evenly
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++)
        while (occ[c][s] > 0) complete(c, s);
    complete(0, 0);
    complete(0, 0);
    send(2'b10, NS * MW);
    send(2'b10, NS * MW);
    send(2'b10, NS * MW);
    send(2'b01, 0);

    // mixed traffic with random completions
    for (int it = 0; it < 150; it++) begin
      logic [1:0] k = 2'($urandom_range(0, 3));
      int n = $urandom_range(0, 5);
      send(k, n);
      if ($urandom_range(0, 9) < 5) begin
        int c = $urandom_range(0, NC - 1);
        int s = $urandom_range(0, NS - 1);
        complete(c, s);
      end
    end

    repeat (4) @(negedge clk);
    check_eq("R2", "pending grants left", q.size(), 0);
    summary();
  end

endmodule